// File: doc/BRIEF.md
# FRL Training FFE Level Tracker

This block watches the per-lane link-training request nibbles that pass over the sink's status side channel during fixed-rate-link training. It keeps one transmit feed-forward equalization level per lane. Each request byte is delivered with a strobe and a lane-pair select. The byte can come from a snooped side-channel read or from a local bus write. Either way, the byte updates the readable copy of the last request seen on its two lanes.

Two request codes act as commands on the level state. The code 0xE moves that lane's level up by one, but never past a configured ceiling. The code 0xF returns every lane to level 0.

The block also decodes the link-rate code into an active lane count and a per-lane rate in Gb/s. A lane that the three-lane modes do not use is masked from all effects. A test bit forces all level outputs to zero. A dedicated synchronous clear resets only this snoop state.

Top module: `frl_ffe_tracker`

## Requirements
- R1: With `wr_pair_i`=0 a write sets lane 0 to `wr_data_i[3:0]` and lane 1 to `wr_data_i[7:4]`. With `wr_pair_i`=1 it sets lane 2 to the low nibble and lane 3 to the high nibble. Lane n's stored request appears on `req_o[4n+3:4n]` from the clock edge that takes the write.
- R2: An accepted request of 0xE raises that lane's level by exactly one, provided the level is below the effective ceiling. Otherwise the level holds.
- R3: An accepted request of 0xF on any lane sets all four levels to 0. This clear wins over a 0xE in the same byte.
- R4: Request codes 0x0 to 0xD only update the stored request and leave every level unchanged.
- R5: The effective ceiling is `ffe_limit_i` when that value is 0 to 3, and 3 for any larger value.
- R6: `frl_rate_i` decodes to (`lane_cnt_o`, `rate_gbps_o`) as follows:
  - 0 → (0, 0)
  - 1 → (3, 3)
  - 2 → (3, 6)
  - 3 → (4, 6)
  - 4 → (4, 8)
  - 5 → (4, 10)
  - 6 → (4, 12)
  - 7 to 15 → (0, 0)
- R7: While `test_no_ffe_i` is 1, every lane field of `ffe_level_o` reads 0. The stored levels are untouched and reappear when the bit drops.
- R8: While the decoded lane count is 3, the lane-3 nibble is ignored. It does not store, does not raise a level and does not trigger a clear. Lane 2 in the same byte is still processed.
- R9: `snoop_rst_i` clears all stored requests and levels at the next clock edge and takes priority over a write in the same cycle.
- R10: After `rst_ni` is asserted, all stored requests and levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| snoop_rst_i | input | 1 | Synchronous clear of request and level state |
| wr_valid_i | input | 1 | Request byte strobe |
| wr_pair_i | input | 1 | Lane pair select: 0 = lanes 0/1, 1 = lanes 2/3 |
| wr_data_i | input | 8 | Request byte, even lane in low nibble |
| ffe_limit_i | input | 4 | Configured highest supported level |
| frl_rate_i | input | 4 | Link rate and lane count code |
| test_no_ffe_i | input | 1 | Test mode: force levels to zero |
| ffe_level_o | output | 8 | Per-lane level, lane n at [2n+1:2n] |
| req_o | output | 16 | Per-lane last request, lane n at [4n+3:4n] |
| lane_cnt_o | output | 3 | Decoded active lane count |
| rate_gbps_o | output | 4 | Decoded per-lane rate in Gb/s |

## Verification
The bench covers saturation at each ceiling, including ceiling values above 3. A design missing the clamp would either wrap the level back to 0 or stop too early.

It sends bytes that mix 0xE and 0xF in one byte. A design with the wrong priority would leave one lane at a non-zero level after a clear.

It drives lane-3 commands in both three-lane modes. A faulty mask would store the nibble or wipe the levels of the other lanes.

It also asserts the snoop clear together with a write, and toggles the no-FFE test bit. A wrong implementation of the test bit would either lose the stored levels or fail to zero the outputs.

// File: rtl/frl_ffe_pkg.sv
package frl_ffe_pkg;
  localparam int NIB_W  = 4;
  localparam int RATE_W = 4;
  localparam logic [NIB_W-1:0] REQ_ADV = 4'hE;
  localparam logic [NIB_W-1:0] REQ_CLR = 4'hF;

  typedef struct packed {
    logic [2:0] lanes;
    logic [3:0] gbps;
  } frl_mode_t;

  function automatic frl_mode_t decode_rate(input logic [RATE_W-1:0] code);
    frl_mode_t m;
    case (code)
      4'd1:    m = '{lanes: 3'd3, gbps: 4'd3};
      4'd2:    m = '{lanes: 3'd3, gbps: 4'd6};
      4'd3:    m = '{lanes: 3'd4, gbps: 4'd6};
      4'd4:    m = '{lanes: 3'd4, gbps: 4'd8};
      4'd5:    m = '{lanes: 3'd4, gbps: 4'd10};
      4'd6:    m = '{lanes: 3'd4, gbps: 4'd12};
      default: m = '{lanes: 3'd0, gbps: 4'd0};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/frl_rate_decode.sv
module frl_rate_decode
  import frl_ffe_pkg::*;
(
  input  logic [RATE_W-1:0] rate_i,
  output logic [2:0]        lanes_o,
  output logic [3:0]        gbps_o,
  output logic              three_lane_o
);
  frl_mode_t mode;

  always_comb begin
    mode         = decode_rate(rate_i);
    lanes_o      = mode.lanes;
    gbps_o       = mode.gbps;
    three_lane_o = (mode.lanes == 3'd3);
  end
endmodule

// File: rtl/frl_ffe_lane.sv
module frl_ffe_lane
  import frl_ffe_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             hit_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             clr_all_i,
  input  logic [LVL_W-1:0] ceil_i,
  output logic [NIB_W-1:0] req_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [NIB_W-1:0] req_q;
  logic [LVL_W-1:0] lvl_q;
  logic             adv;

  assign adv = hit_i && (nib_i == REQ_ADV) && (lvl_q < ceil_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      lvl_q <= '0;
    end else if (srst_i) begin
      req_q <= '0;
      lvl_q <= '0;
    end else begin
      if (hit_i) req_q <= nib_i;
      // a clear from any lane beats a local advance
      if (clr_all_i)  lvl_q <= '0;
      else if (adv)   lvl_q <= lvl_q + 1'b1;
    end
  end

  assign req_o = req_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/frl_ffe_tracker.sv
module frl_ffe_tracker
  import frl_ffe_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LVL_W     = 2,
  parameter int LIMIT_W   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       snoop_rst_i,
  input  logic                       wr_valid_i,
  input  logic                       wr_pair_i,
  input  logic [2*NIB_W-1:0]         wr_data_i,
  input  logic [LIMIT_W-1:0]         ffe_limit_i,
  input  logic [RATE_W-1:0]          frl_rate_i,
  input  logic                       test_no_ffe_i,
  output logic [NUM_LANES*LVL_W-1:0] ffe_level_o,
  output logic [NUM_LANES*NIB_W-1:0] req_o,
  output logic [2:0]                 lane_cnt_o,
  output logic [3:0]                 rate_gbps_o
);
  localparam int LVL_MAX = (1 << LVL_W) - 1;
  localparam int TOP_LN  = NUM_LANES - 1;

  logic                 three_lane;
  logic [LVL_W-1:0]     ceil;
  logic [NUM_LANES-1:0] hit;
  logic [NUM_LANES-1:0] is_clr;
  logic                 clr_all;
  logic [LVL_W-1:0]     lvl [NUM_LANES];

  frl_rate_decode i_dec (
    .rate_i       (frl_rate_i),
    .lanes_o      (lane_cnt_o),
    .gbps_o       (rate_gbps_o),
    .three_lane_o (three_lane)
  );

  assign ceil    = (ffe_limit_i > LIMIT_W'(LVL_MAX)) ? LVL_W'(LVL_MAX)
                                                     : ffe_limit_i[LVL_W-1:0];
  assign clr_all = |is_clr;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [NIB_W-1:0] nib;
    logic             masked;

    assign nib       = wr_data_i[(i%2)*NIB_W +: NIB_W];
    assign masked    = (i == TOP_LN) && three_lane;
    assign hit[i]    = wr_valid_i && (wr_pair_i == 1'((i/2) % 2)) && !masked;
    assign is_clr[i] = hit[i] && (nib == REQ_CLR);

    frl_ffe_lane #(.LVL_W(LVL_W)) i_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .srst_i    (snoop_rst_i),
      .hit_i     (hit[i]),
      .nib_i     (nib),
      .clr_all_i (clr_all),
      .ceil_i    (ceil),
      .req_o     (req_o[i*NIB_W +: NIB_W]),
      .lvl_o     (lvl[i])
    );

    assign ffe_level_o[i*LVL_W +: LVL_W] = test_no_ffe_i ? '0 : lvl[i];
  end
endmodule

// File: rtl/frl_ffe_tracker_chk.sv
module frl_ffe_tracker_chk
  import frl_ffe_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LVL_W     = 2,
  parameter int LIMIT_W   = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       snoop_rst_i,
  input logic                       wr_valid_i,
  input logic                       wr_pair_i,
  input logic [2*NIB_W-1:0]         wr_data_i,
  input logic [LIMIT_W-1:0]         ffe_limit_i,
  input logic [RATE_W-1:0]          frl_rate_i,
  input logic                       test_no_ffe_i,
  input logic [NUM_LANES*LVL_W-1:0] ffe_level_o,
  input logic [NUM_LANES*NIB_W-1:0] req_o,
  input logic [2:0]                 lane_cnt_o,
  input logic [3:0]                 rate_gbps_o
);
  logic             thr;
  logic             any_clr;
  logic [LVL_W-1:0] ceil_c;

  assign thr     = (frl_rate_i == 4'd1) || (frl_rate_i == 4'd2);
  assign any_clr = wr_valid_i && !snoop_rst_i &&
                   ((wr_data_i[3:0] == REQ_CLR) ||
                    ((wr_data_i[7:4] == REQ_CLR) && !(wr_pair_i && thr)));
  assign ceil_c  = (ffe_limit_i > 4'd3) ? 2'd3 : ffe_limit_i[1:0];

  AST_NOFFE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_no_ffe_i |-> ffe_level_o == '0); // R7

  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_clr |=> (test_no_ffe_i || ffe_level_o == '0)); // R3

  AST_SNOOP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_rst_i |=> req_o == '0); // R9

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_valid_i && !snoop_rst_i) |=> $stable(req_o)); // R1

  AST_LANE3_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_pair_i && thr && !snoop_rst_i) |=> $stable(req_o[15:12])); // R8

  AST_LVL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_no_ffe_i && $past(!test_no_ffe_i) && ffe_level_o[1:0] > $past(ffe_level_o[1:0]))
      |-> (ffe_level_o[1:0] == $past(ffe_level_o[1:0]) + 2'd1) &&
          (ffe_level_o[1:0] <= $past(ceil_c))); // R2

  AST_LANE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_cnt_o == 3'd0) |-> (rate_gbps_o == 4'd0)); // R6
endmodule

bind frl_ffe_tracker frl_ffe_tracker_chk #(
  .NUM_LANES (NUM_LANES),
  .LVL_W     (LVL_W),
  .LIMIT_W   (LIMIT_W)
) i_chk (.*);

// File: tb/test_frl_ffe_tracker.sv
module test_frl_ffe_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srst = 1'b0;
  logic        wv = 1'b0;
  logic        wp = 1'b0;
  logic [7:0]  wd = '0;
  logic [3:0]  lim = 4'd3;
  logic [3:0]  rate = 4'd6;
  logic        noffe = 1'b0;
  logic [7:0]  lvl_o;
  logic [15:0] req_o;
  logic [2:0]  lcnt;
  logic [3:0]  gbps;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [3:0] m_req [4];
  logic [1:0] m_lvl [4];

  always #10 clk = ~clk;

  frl_ffe_tracker i_frl_ffe_tracker (
    .clk_i(clk), .rst_ni(rst_n), .snoop_rst_i(srst), .wr_valid_i(wv),
    .wr_pair_i(wp), .wr_data_i(wd), .ffe_limit_i(lim), .frl_rate_i(rate),
    .test_no_ffe_i(noffe), .ffe_level_o(lvl_o), .req_o(req_o),
    .lane_cnt_o(lcnt), .rate_gbps_o(gbps));

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_lanes(input logic [3:0] c);
    if (c == 1 || c == 2) return 3;
    if (c >= 3 && c <= 6) return 4;
    return 0;
  endfunction

  function automatic int exp_gbps(input logic [3:0] c);
    case (c)
      4'd1: return 3;
      4'd2, 4'd3: return 6;
      4'd4: return 8;
      4'd5: return 10;
      4'd6: return 12;
      default: return 0;
    endcase
  endfunction

  task automatic model(input logic pair, input logic [7:0] d, input logic sr);
    bit clr = 0;
    bit three = (exp_lanes(rate) == 3);
    logic [1:0] ce = (lim > 3) ? 2'd3 : lim[1:0];
    if (sr) begin
      for (int i = 0; i < 4; i++) begin m_req[i] = 0; m_lvl[i] = 0; end
      return;
    end
    for (int h = 0; h < 2; h++) begin
      int ln = pair * 2 + h;
      logic [3:0] nb = d[h*4 +: 4];
      if (!(ln == 3 && three)) begin
        m_req[ln] = nb;
        if (nb == 4'hF) clr = 1;
        if (nb == 4'hE && m_lvl[ln] < ce) m_lvl[ln] = m_lvl[ln] + 1;
      end
    end
    if (clr) for (int i = 0; i < 4; i++) m_lvl[i] = 0;
  endtask

  task automatic compare(input string tag);
    for (int i = 0; i < 4; i++) begin
      check({tag, " req"}, req_o[i*4 +: 4], m_req[i]);
      check({tag, " lvl"}, lvl_o[i*2 +: 2], noffe ? 0 : m_lvl[i]);
    end
  endtask

  // called at a negedge; returns at the following negedge with outputs settled
  task automatic step(input logic v, input logic pair, input logic [7:0] d,
                      input logic sr, input string tag);
    wv = v; wp = pair; wd = d; srst = sr;
    @(negedge clk);
    if (sr) model(pair, d, 1'b1);
    else if (v) model(pair, d, 1'b0);
    wv = 0; srst = 0;
    compare(tag);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    end
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_req[i] = 0; m_lvl[i] = 0; end
    repeat (3) @(negedge clk);
    compare("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R6 every rate code
    for (int c = 0; c < 16; c++) begin
      rate = 4'(c); #1;
      check("R6 lanes", lcnt, exp_lanes(4'(c)));
      check("R6 gbps", gbps, exp_gbps(4'(c)));
    end
    rate = 4'd6; lim = 4'd3;
    @(negedge clk);

    step(1, 0, 8'h21, 0, "R1 pair0");
    step(1, 1, 8'hD4, 0, "R1 pair1 R4");
    for (int k = 0; k < 4; k++) step(1, 0, 8'h0E, 0, "R2 sat lane0");
    lim = 4'd1;
    for (int k = 0; k < 2; k++) step(1, 0, 8'hE0, 0, "R2 limit1 lane1");
    lim = 4'd9;
    for (int k = 0; k < 4; k++) step(1, 1, 8'h0E, 0, "R5 clamp lane2");
    step(1, 1, 8'h5A, 0, "R4 no level change");
    step(1, 0, 8'hFE, 0, "R3 clear wins");
    step(1, 1, 8'hEE, 0, "R2 both lanes");
    step(1, 1, 8'hEE, 0, "R2 both lanes");
    noffe = 1; #1; compare("R7 forced zero");
    step(1, 0, 8'h0E, 0, "R7 update while forced");
    noffe = 0; #1; compare("R7 restore");
    rate = 4'd1;
    step(1, 1, 8'hF3, 0, "R8 lane3 F ignored");
    step(1, 1, 8'hE3, 0, "R8 lane3 E ignored");
    rate = 4'd2;
    step(1, 1, 8'h7E, 0, "R8 lane2 still live");
    rate = 4'd5;
    step(1, 1, 8'hF1, 0, "R3 lane3 clear at 4 lanes");
    step(1, 0, 8'hEE, 0, "R2 refill");
    step(1, 0, 8'hEE, 1, "R9 srst beats write");

    void'($urandom(32'd1234));
    for (int k = 0; k < 600; k++) begin
      logic [7:0] d;
      int sel = $urandom_range(0, 9);
      d = 8'($urandom);
      if (sel < 4) d[3:0] = 4'hE;
      if (sel < 2) d[7:4] = 4'hE;
      if (sel == 9) d[7:4] = 4'hF;
      if ($urandom_range(0, 15) == 0) rate = 4'($urandom);
      if ($urandom_range(0, 15) == 0) lim = 4'($urandom);
      noffe = ($urandom_range(0, 19) == 0);
      step($urandom_range(0, 4) != 0, 1'($urandom), d,
           $urandom_range(0, 49) == 0, "R1 R2 R3 R8 random");
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    end
    $finish;
  end
endmodule